// File: doc/BRIEF.md
# SMBus Target Front End with Clock-Low Timeout

This block is the bus-facing part of an SMBus/I2C target. It samples SCL and SDA, which arrive already synchronised, with the system clock. It recognises START, repeated START and STOP conditions, then shifts in the address byte. It acknowledges only its own 7-bit address. After that it either receives write bytes, handing each one out with a one-cycle strobe, or sends read bytes taken from a byte input, MSB first. The block never drives SCL, so it never stretches the clock. Every SDA change it makes is placed a fixed number of system cycles after the SCL falling edge. This keeps its data hold time inside the legal window and away from a false START or STOP.

A counter measures each SCL-low interval while a transfer is in progress. If one interval reaches the timeout threshold, the block does three things: it lets go of SDA, it pulses a timeout event, and it drops back to idle, ready for a fresh START. The threshold is a parameter in system cycles. Set it so that the interval falls between 25 ms and 35 ms at the real clock rate. A legal bus clock (10 kHz to 400 kHz) can never trip it. An enable input works as the capability bit. When the input is low, no interval, however long, ends a transfer.

Top module: `smb_tgt`

## Requirements
- R1: After reset, sdaOut is 0 (SDA released), and rxValid, txLoad and timeoutPulse are 0.
- R2: A STOP (SDA rising while SCL is high) releases SDA at once and returns the block to idle. A START or repeated START (SDA falling while SCL is high) releases SDA and restarts address reception from any state.
- R3: The first byte after START is taken MSB first on SCL rising edges. Its upper 7 bits are the address and bit 0 is the direction (1 = read, 0 = write). The block drives an ACK (sdaOut = 1) during the ninth clock only when the address equals ownAddr. On a mismatch it leaves SDA released and ignores the bus until the next START.
- R4: In write mode, each byte completes on its eighth rising edge. At that point rxData holds the byte and rxValid is high for exactly one cycle, and the block drives an ACK during the ninth clock.
- R5: In read mode, txData is captured and txLoad pulses on the rising edge that ends the address ACK and on each master ACK (SDA low on the ninth clock). Each captured byte is sent MSB first, with a 0 bit driven low and a 1 bit released. A master NACK returns the block to idle with SDA released.
- R6: sdaOut changes after an SCL falling edge exactly HOLD_CYC system cycles after the clock edge that samples that fall, and at no other time except an abort.
- R7: With toEnable = 1 and a transfer in progress, TIMEOUT_CYC consecutive samples of SCL low make timeoutPulse high for one cycle, release SDA and return the block to idle. The next START is accepted normally.
- R8: With toEnable = 0, no SCL-low interval of any length produces timeoutPulse or disturbs a driven ACK.
- R9: The low-time count restarts whenever SCL is sampled high, so a transfer made of many low intervals, each shorter than TIMEOUT_CYC, is never aborted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Synchronised SCL level |
| sdaIn | input | 1 | Synchronised SDA level |
| ownAddr | input | 7 | Address this target answers to |
| toEnable | input | 1 | Capability bit: 1 enables the clock-low timeout |
| txData | input | 8 | Next byte to send in read mode |
| sdaOut | output | 1 | SDA pull-down: 1 drives the line low |
| rxData | output | 8 | Last byte received in write mode |
| rxValid | output | 1 | One-cycle strobe: rxData holds a new byte |
| txLoad | output | 1 | One-cycle strobe: txData was captured |
| timeoutPulse | output | 1 | One-cycle strobe: a transfer was abandoned on timeout |

## Verification
The bench measures the delay from a sampled SCL fall to the ACK appearing. An off-by-one hold counter would shift that edge by a cycle. Logic that ignored the delay would move SDA right at the fall, where it could be seen as a false START or STOP. The timeout is exercised three ways: once while the block holds an ACK low, once with the enable cleared, and once with a slow transfer whose intervals each stay just under the threshold. A counter that never cleared on SCL high would abort the slow transfer. A design that ignored the enable would drop the ACK. A design that did not release SDA on timeout would leave the bus stuck low. Repeated START, a mismatched address and a read ended by NACK check that each exit path really releases SDA and returns to a state that accepts the next START.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WRITE,
    ST_WR_ACK,
    ST_READ,
    ST_RD_ACK
  } tgtState_e;

  // Observations the datapath reports to the control
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sdaBit;
    logic byteDone;
    logic addrHit;
    logic txBit;
    logic toFire;
  } busEvents_t;

  // Strobes the control issues to the datapath
  typedef struct packed {
    logic active;
    logic abort;
    logic clrBits;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic rxStrobe;
    logic schedule;
    logic driveVal;
  } dpCtrl_t;

endpackage

// File: rtl/smb_tgt_datapath.sv
module smb_tgt_datapath
  import smb_tgt_pkg::*;
#(
  parameter int HOLD_CYC    = 50,
  parameter int TIMEOUT_CYC = 3_750_000,
  parameter int ADDR_W      = 7,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              toEnable,
  input  logic [BYTE_W-1:0] txData,
  input  dpCtrl_t           ctrl,
  output busEvents_t        ev,
  output logic              sdaDrv,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic              txLoad,
  output logic              timeoutPulse
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam int TO_W   = $clog2(TIMEOUT_CYC + 1);
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [TO_W-1:0]   TO_LAST   = TO_W'(TIMEOUT_CYC - 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0]  BIT_LAST  = CNT_W'(BYTE_W - 1);

  logic              sclQ, sdaQ;
  logic [BYTE_W-1:0] shReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              pendVal;
  logic [TO_W-1:0]   lowCnt;
  logic              toFire;

  // Bus condition detection against the previous sample
  always_comb begin
    ev.start    = sclQ & sclIn & sdaQ & ~sdaIn;
    ev.stop     = sclQ & sclIn & ~sdaQ & sdaIn;
    ev.rise     = ~sclQ & sclIn;
    ev.fall     = sclQ & ~sclIn;
    ev.sdaBit   = sdaIn;
    ev.byteDone = (bitCnt == BIT_LAST);
    ev.addrHit  = (shReg[ADDR_W-1:0] == ownAddr);
    ev.txBit    = shReg[BYTE_W-1];
    ev.toFire   = toFire;
  end

  assign toFire = toEnable & ctrl.active & ~sclIn & (lowCnt == TO_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  // Shift register, bit counter and byte strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      bitCnt  <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
      txLoad  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      txLoad  <= 1'b0;
      if (ctrl.clrBits) bitCnt <= '0;
      if (ctrl.shiftIn) begin
        shReg  <= {shReg[BYTE_W-2:0], sdaIn};
        bitCnt <= bitCnt + 1'b1;
      end
      if (ctrl.shiftOut) begin
        shReg  <= {shReg[BYTE_W-2:0], 1'b0};
        bitCnt <= bitCnt + 1'b1;
      end
      if (ctrl.loadTx) begin
        shReg  <= txData;
        bitCnt <= '0;
        txLoad <= 1'b1;
      end
      if (ctrl.rxStrobe) begin
        rxData  <= {shReg[BYTE_W-2:0], sdaIn};
        rxValid <= 1'b1;
      end
    end
  end

  // Delayed SDA drive after each SCL fall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
      pendVal <= 1'b0;
      sdaDrv  <= 1'b0;
    end else if (ctrl.abort) begin
      holdCnt <= '0;
      sdaDrv  <= 1'b0;
    end else if (ctrl.schedule) begin
      pendVal <= ctrl.driveVal;
      holdCnt <= HOLD_LOAD;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
      if (holdCnt == HOLD_W'(1)) sdaDrv <= pendVal;
    end
  end

  // SCL-low interval timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt       <= '0;
      timeoutPulse <= 1'b0;
    end else begin
      timeoutPulse <= toFire;
      if (!toEnable || !ctrl.active || sclIn || toFire) lowCnt <= '0;
      else                                              lowCnt <= lowCnt + 1'b1;
    end
  end

  // R6: SDA only moves when the hold delay expires or on an abort
  a_r6_sda_on_expiry: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrv) |-> ($past(holdCnt) == HOLD_W'(1) || $past(ctrl.abort)));

  // R7: the timeout event is a single-cycle pulse and SDA is free with it
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> !sdaDrv);

  // R8: disabled timer never reports
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !$past(toEnable) |-> !timeoutPulse);

  // R4: byte strobe lasts one cycle
  a_r4_rx_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

endmodule

// File: rtl/smb_tgt_control.sv
module smb_tgt_control
  import smb_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEvents_t ev,
  output dpCtrl_t    ctrl
);

  tgtState_e state, stateNext;
  logic      rdMode, rdModeNext;

  always_comb begin
    ctrl        = '0;
    stateNext   = state;
    rdModeNext  = rdMode;
    ctrl.active = (state != ST_IDLE);
    if (ev.toFire || ev.stop) begin
      ctrl.abort = 1'b1;
      stateNext  = ST_IDLE;
    end else if (ev.start) begin
      ctrl.abort   = 1'b1;
      ctrl.clrBits = 1'b1;
      stateNext    = ST_ADDR;
    end else if (ev.fall && state != ST_IDLE) begin
      ctrl.schedule = 1'b1;
      unique case (state)
        ST_ADDR_ACK, ST_WR_ACK: ctrl.driveVal = 1'b1;
        ST_READ:                ctrl.driveVal = ~ev.txBit;
        default:                ctrl.driveVal = 1'b0;
      endcase
    end else if (ev.rise) begin
      unique case (state)
        ST_ADDR: begin
          ctrl.shiftIn = 1'b1;
          if (ev.byteDone) begin
            if (ev.addrHit) begin
              stateNext  = ST_ADDR_ACK;
              rdModeNext = ev.sdaBit;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (rdMode) begin
            ctrl.loadTx = 1'b1;
            stateNext   = ST_READ;
          end else begin
            ctrl.clrBits = 1'b1;
            stateNext    = ST_WRITE;
          end
        end
        ST_WRITE: begin
          ctrl.shiftIn = 1'b1;
          if (ev.byteDone) begin
            ctrl.rxStrobe = 1'b1;
            stateNext     = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          ctrl.clrBits = 1'b1;
          stateNext    = ST_WRITE;
        end
        ST_READ: begin
          ctrl.shiftOut = 1'b1;
          if (ev.byteDone) stateNext = ST_RD_ACK;
        end
        ST_RD_ACK: begin
          if (!ev.sdaBit) begin
            ctrl.loadTx = 1'b1;
            stateNext   = ST_READ;
          end else begin
            stateNext = ST_IDLE;
          end
        end
        default: stateNext = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rdMode <= 1'b0;
    end else begin
      state  <= stateNext;
      rdMode <= rdModeNext;
    end
  end

  // R2: STOP always lands in idle; START always restarts address phase
  a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rstN)
    ev.stop |=> state == ST_IDLE);
  a_r2_start_addr: assert property (@(posedge clk) disable iff (!rstN)
    (ev.start && !ev.toFire) |=> state == ST_ADDR);

  // R3: a mismatched address drops the transfer
  a_r3_miss_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && ev.rise && ev.byteDone && !ev.addrHit && !ev.toFire)
      |=> state == ST_IDLE);

  // R7: timeout abandons the transfer
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    ev.toFire |=> state == ST_IDLE);

endmodule

// File: rtl/smb_tgt.sv
module smb_tgt
  import smb_tgt_pkg::*;
#(
  parameter int HOLD_CYC    = 50,
  parameter int TIMEOUT_CYC = 3_750_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [6:0] ownAddr,
  input  logic       toEnable,
  input  logic [7:0] txData,
  output logic       sdaOut,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       txLoad,
  output logic       timeoutPulse
);

  busEvents_t ev;
  dpCtrl_t    ctrl;

  smb_tgt_datapath #(
    .HOLD_CYC   (HOLD_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .ADDR_W     (7),
    .BYTE_W     (8)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .ownAddr     (ownAddr),
    .toEnable    (toEnable),
    .txData      (txData),
    .ctrl        (ctrl),
    .ev          (ev),
    .sdaDrv      (sdaOut),
    .rxData      (rxData),
    .rxValid     (rxValid),
    .txLoad      (txLoad),
    .timeoutPulse(timeoutPulse)
  );

  smb_tgt_control u_control (
    .clk (clk),
    .rstN(rstN),
    .ev  (ev),
    .ctrl(ctrl)
  );

endmodule

// File: tb/smb_tgt_bench.sv
module smb_tgt_bench;

  localparam int HOLD  = 50;
  localparam int TO    = 3000;
  localparam int LOWC  = 200;
  localparam int HIGHC = 200;
  localparam logic [6:0] MYADDR = 7'h4B;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic       toEnable = 1'b1;
  logic [7:0] txData = 8'h00;
  logic       sdaOut, rxValid, txLoad, timeoutPulse;
  logic [7:0] rxData;
  logic       sdaBus;

  int vecs = 0;
  int errs = 0;
  int toCount = 0;
  logic [7:0] rxQ[$];

  assign sdaBus = sdaM & ~sdaOut;

  always #4 clk = ~clk;

  smb_tgt #(.HOLD_CYC(HOLD), .TIMEOUT_CYC(TO)) u_smb_tgt (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .ownAddr(MYADDR), .toEnable(toEnable), .txData(txData),
    .sdaOut(sdaOut), .rxData(rxData), .rxValid(rxValid),
    .txLoad(txLoad), .timeoutPulse(timeoutPulse)
  );

  // ---------------- behavioural reference model ----------------
  int   mState;            // 0 idle 1 addr 2 addrAck 3 write 4 wrAck 5 read 6 rdAck
  int   mBits, mLow, cyc;
  bit   mRd, mPrevScl, mPrevSda;
  bit [7:0] mShift;
  bit   mDrv, mRxV, mTxL, mTo;
  bit [7:0] mRx;
  int   dueQ[$];
  bit   valQ[$];

  always @(posedge clk) begin
    bit s, d, st, sp, rs, fl, fire;
    s = sclM; d = sdaBus;
    mRxV = 0; mTxL = 0; mTo = 0;
    if (!rstN) begin
      mState = 0; mBits = 0; mLow = 0; mRd = 0; mShift = 0; mDrv = 0;
      mRx = 0; mPrevScl = 1; mPrevSda = 1; dueQ.delete(); valQ.delete();
    end else begin
      st = mPrevScl && s && mPrevSda && !d;
      sp = mPrevScl && s && !mPrevSda && d;
      rs = !mPrevScl && s;
      fl = mPrevScl && !s;
      fire = toEnable && mState != 0 && !s && mLow == TO - 1;
      if (!toEnable || mState == 0 || s || fire) mLow = 0; else mLow++;
      mTo = fire;
      if (dueQ.size() > 0 && dueQ[0] == cyc) begin
        mDrv = valQ[0]; void'(dueQ.pop_front()); void'(valQ.pop_front());
      end
      if (fire || sp) begin
        mState = 0; mDrv = 0; dueQ.delete(); valQ.delete();
      end else if (st) begin
        mState = 1; mBits = 0; mDrv = 0; dueQ.delete(); valQ.delete();
      end else if (fl && mState != 0) begin
        dueQ.delete(); valQ.delete();
        dueQ.push_back(cyc + HOLD);
        valQ.push_back((mState == 2 || mState == 4) ? 1'b1 :
                       (mState == 5) ? !mShift[7] : 1'b0);
      end else if (rs) begin
        case (mState)
          1: begin
            mShift = {mShift[6:0], d}; mBits++;
            if (mBits == 8) begin
              if (mShift[7:1] == MYADDR) begin mState = 2; mRd = d; end
              else mState = 0;
            end
          end
          2: if (mRd) begin mShift = txData; mBits = 0; mTxL = 1; mState = 5; end
             else begin mBits = 0; mState = 3; end
          3: begin
            mShift = {mShift[6:0], d}; mBits++;
            if (mBits == 8) begin mRx = mShift; mRxV = 1; mState = 4; end
          end
          4: begin mBits = 0; mState = 3; end
          5: begin
            mShift = {mShift[6:0], 1'b0}; mBits++;
            if (mBits == 8) mState = 6;
          end
          6: if (!d) begin mShift = txData; mBits = 0; mTxL = 1; mState = 5; end
             else mState = 0;
          default: ;
        endcase
      end
      cyc++;
    end
    mPrevScl = rstN ? s : 1'b1;
    mPrevSda = rstN ? d : 1'b1;
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      vecs++;
      if (sdaOut !== mDrv) begin errs++;
        $display("FAIL R6 sdaOut actual=%0b expected=%0b t=%0t", sdaOut, mDrv, $time); end
      if (rxValid !== mRxV || rxData !== mRx) begin errs++;
        $display("FAIL R4 rxValid/rxData actual=%0b/%0h expected=%0b/%0h", rxValid, rxData, mRxV, mRx); end
      if (txLoad !== mTxL) begin errs++;
        $display("FAIL R5 txLoad actual=%0b expected=%0b", txLoad, mTxL); end
      if (timeoutPulse !== mTo) begin errs++;
        $display("FAIL R7 timeoutPulse actual=%0b expected=%0b", timeoutPulse, mTo); end
      if (timeoutPulse) toCount++;
      if (rxValid) rxQ.push_back(rxData);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitc(20);
    sclM = 1'b1; waitc(HIGHC / 2);
    sdaM = 1'b0; waitc(HIGHC / 2);
    sclM = 1'b0;
  endtask

  task automatic busStop();
    waitc(20); sdaM = 1'b0; waitc(LOWC);
    sclM = 1'b1; waitc(HIGHC / 2);
    sdaM = 1'b1; waitc(HIGHC);
  endtask

  task automatic bitOut(input bit b, input int lowLen);
    waitc(20); sdaM = b; waitc(lowLen - 20);
    sclM = 1'b1; waitc(HIGHC);
    sclM = 1'b0;
  endtask

  task automatic bitIn(output bit b, input int lowLen);
    waitc(20); sdaM = 1'b1; waitc(lowLen - 20);
    sclM = 1'b1; waitc(HIGHC / 2);
    b = sdaBus; waitc(HIGHC / 2);
    sclM = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] v, output bit acked, input int lowLen);
    bit b;
    for (int i = 7; i >= 0; i--) bitOut(v[i], lowLen);
    bitIn(b, lowLen);
    acked = !b;
  endtask

  task automatic readByte(output logic [7:0] v, input bit ack, input logic [7:0] nextTx);
    bit b;
    for (int i = 7; i >= 0; i--) begin bitIn(b, LOWC); v[i] = b; end
    txData = nextTx;
    bitOut(!ack, LOWC);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    bit ack, b;
    logic [7:0] rv;
    int k;
    waitc(5);
    chk("R1 sdaOut after reset", sdaOut, 0);
    chk("R1 rxValid after reset", rxValid, 0);
    chk("R1 txLoad after reset", txLoad, 0);
    chk("R1 timeoutPulse after reset", timeoutPulse, 0);
    rstN = 1'b1;
    waitc(10);

    // write transfer, two data bytes
    busStart();
    writeByte({MYADDR, 1'b0}, ack, LOWC); chk("R3 own address acked", ack, 1);
    writeByte(8'hA5, ack, LOWC);          chk("R4 data byte 1 acked", ack, 1);
    writeByte(8'h3C, ack, LOWC);          chk("R4 data byte 2 acked", ack, 1);
    busStop();
    chk("R2 released after STOP", sdaOut, 0);
    chk("R4 two bytes received", rxQ.size(), 2);
    if (rxQ.size() == 2) begin
      chk("R4 first byte", rxQ[0], 8'hA5);
      chk("R4 second byte", rxQ[1], 8'h3C);
    end
    rxQ.delete();

    // wrong address
    busStart();
    writeByte({MYADDR ^ 7'h01, 1'b0}, ack, LOWC); chk("R3 foreign address not acked", ack, 0);
    writeByte(8'h00, ack, LOWC);                  chk("R3 bytes ignored after mismatch", ack, 0);
    busStop();
    chk("R3 nothing received after mismatch", rxQ.size(), 0);

    // read transfer, ACK then NACK
    txData = 8'hC3;
    busStart();
    writeByte({MYADDR, 1'b1}, ack, LOWC); chk("R3 read address acked", ack, 1);
    readByte(rv, 1'b1, 8'h5A);            chk("R5 first read byte", rv, 8'hC3);
    readByte(rv, 1'b0, 8'hFF);            chk("R5 second read byte", rv, 8'h5A);
    waitc(HOLD + 5);
    chk("R5 released after master NACK", sdaOut, 0);
    busStop();

    // repeated START from write into read
    busStart();
    writeByte({MYADDR, 1'b0}, ack, LOWC);
    writeByte(8'h11, ack, LOWC);
    txData = 8'h96;
    busStart();
    writeByte({MYADDR, 1'b1}, ack, LOWC); chk("R2 repeated START address acked", ack, 1);
    readByte(rv, 1'b0, 8'h00);            chk("R2 read after repeated START", rv, 8'h96);
    busStop();
    rxQ.delete();

    // ACK timing after SCL fall
    busStart();
    for (int i = 7; i >= 0; i--) bitOut(i == 0 ? 1'b0 : MYADDR[i-1], LOWC);
    k = 0;
    for (int j = 1; j <= LOWC - 30; j++) begin
      @(negedge clk);
      if (sdaOut && k == 0) k = j;
    end
    chk("R6 ACK delay from sampled fall", k, HOLD + 1);
    waitc(30); sclM = 1'b1; waitc(HIGHC); sclM = 1'b0;
    busStop();

    // timeout while ACK is driven
    busStart();
    for (int i = 7; i >= 0; i--) bitOut(i == 0 ? 1'b0 : MYADDR[i-1], LOWC);
    waitc(TO + 100);
    chk("R7 one timeout event", toCount, 1);
    chk("R7 SDA released after timeout", sdaOut, 0);
    sclM = 1'b1; waitc(HIGHC);
    busStart();
    writeByte({MYADDR, 1'b0}, ack, LOWC); chk("R7 new START accepted", ack, 1);
    busStop();

    // timeout disabled
    toEnable = 1'b0;
    busStart();
    for (int i = 7; i >= 0; i--) bitOut(i == 0 ? 1'b0 : MYADDR[i-1], LOWC);
    waitc(TO + 500);
    chk("R8 ACK still driven with timer off", sdaOut, 1);
    chk("R8 no timeout event", toCount, 1);
    sclM = 1'b1; waitc(HIGHC); sclM = 1'b0;
    busStop();
    toEnable = 1'b1;

    // slow transfer just under the threshold
    busStart();
    writeByte({MYADDR, 1'b0}, ack, TO - 200); chk("R9 slow address acked", ack, 1);
    writeByte(8'h7E, ack, TO - 200);          chk("R9 slow byte acked", ack, 1);
    busStop();
    chk("R9 no timeout on slow clock", toCount, 1);
    chk("R9 slow byte received", rxQ.size() > 0 ? rxQ[rxQ.size()-1] : 0, 8'h7E);

    waitc(20);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule